// File: doc/BRIEF.md
# Byte-Wide Indirect Register Bridge

This block lets a host with an 8-bit bus reach a bank of 32-bit registers inside the chip. The host first writes a register index to an index location. It then moves one 32-bit word through four byte locations that follow one another. The byte at the lowest of these locations carries the most significant bits. The host must access these bytes one at a time, in rising address order.

For a write, the bridge holds the incoming bytes in a staging word. The register port sees the whole word in a single commit, and only after the last byte arrives in the correct order. For a read, the first byte access takes a snapshot of the selected register. The three later bytes come from that snapshot, so the host gets one consistent word even if the register changes partway through.

One index is served inside the bridge. It holds a fixed identification word, made of implementation, version and port-count fields. All other indices are passed to the internal register port.

Top module: `ibr_bridge`

## Requirements
- R1: After reset, `reg_idx` is 0, `hst_rdata` is 0 and `reg_wr` is low.
- R2: A host write to address 0 loads `reg_idx` from the next clock edge on. `reg_idx` changes at no other time. A host read of address 0 returns the current index.
- R3: Data addresses 4, 5, 6 and 7 carry word bits 31:24, 23:16, 15:8 and 7:0 respectively. A committed word equals the four written bytes placed in those lanes.
- R4: `reg_wr` is a single-cycle pulse. It is high in the cycle after a write to address 7, and only when addresses 4, 5 and 6 were written in that order since the last commit, sequence break or index write.
- R5: Writes to addresses 4, 5 and 6 never raise `reg_wr`.
- R6: A write to address 4 always starts a new sequence. A write to address 5, 6 or 7 that is out of order is dropped and clears the sequence, so a later write to address 7 does not commit.
- R7: A write to address 0 abandons a partly written word, so a later write to address 7 does not commit.
- R8: A read of address 4 captures the selected 32-bit word. Reads of addresses 5 to 7 return bytes of that captured word, even if `reg_rdata` has changed since.
- R9: Read data appears on `hst_rdata` in the cycle after the read strobe and holds until the next read. Lanes follow the mapping in R3. A read of addresses 1 to 3 returns 0.
- R10: Index 0 is the identification register. Reading it returns {IMPL_CODE, VER_CODE, PORT_COUNT, 8'h00} and does not raise `reg_rd`. A complete write sequence to it does not raise `reg_wr`.
- R11: `reg_rd` is high only in the cycle of a host read of address 4, and only while the index is not the identification index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_sel | input | 1 | Host byte access strobe, one cycle per access |
| hst_wr | input | 1 | 1 = write access, 0 = read access |
| hst_addr | input | 3 | Host byte address: 0 = index, 4..7 = data lanes |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte, registered |
| reg_idx | output | 8 | Selected internal register index |
| reg_wr | output | 1 | Commit pulse for the internal register write |
| reg_wdata | output | 32 | Committed word |
| reg_rd | output | 1 | Snapshot strobe toward the internal register |
| reg_rdata | input | 32 | Internal register read value, combinational from reg_idx |

## Verification
The hardest cases are the sequences that look almost complete but must not commit. One is a write to address 7 that comes after a skipped lane. Another is one that comes after a fresh index write, which abandons the word being built. The bench builds each of these from ordinary single-byte tasks: it writes the leading lanes, breaks the order or rewrites the index, and then issues the final lane. At that point it checks that no commit pulse appears, and then that a clean sequence right after it does commit. The snapshot case is reached by changing the modelled register value between the first and second byte reads.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = LANE_W * LANES;
  localparam int LSEL_W = $clog2(LANES);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [LSEL_W-1:0] lsel_t;

  // lane 0 is the most significant byte
  function automatic lane_t lane_get(word_t w, lsel_t k);
    return w[(LANES - 1 - int'(k)) * LANE_W +: LANE_W];
  endfunction

  function automatic word_t lane_put(word_t w, lsel_t k, lane_t b);
    word_t r;
    r = w;
    r[(LANES - 1 - int'(k)) * LANE_W +: LANE_W] = b;
    return r;
  endfunction

  function automatic word_t id_word(lane_t impl, lane_t ver, lane_t ports);
    return {impl, ver, ports, {LANE_W{1'b0}}};
  endfunction
endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
  import ibr_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int IDX_ADDR  = 0,
  parameter int DATA_BASE = 4
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              dat_wr,
  output logic              dat_rd,
  output logic              other_rd,
  output lsel_t             lane
);
  logic in_data;
  logic is_idx;
  logic [ADDR_W-1:0] offs;

  always_comb begin
    offs     = addr - ADDR_W'(DATA_BASE);
    in_data  = (int'(addr) >= DATA_BASE) && (int'(addr) < DATA_BASE + LANES);
    is_idx   = (int'(addr) == IDX_ADDR);
    lane     = offs[LSEL_W-1:0];
    idx_wr   = sel && wr && is_idx;
    idx_rd   = sel && !wr && is_idx;
    dat_wr   = sel && wr && in_data;
    dat_rd   = sel && !wr && in_data;
    other_rd = sel && !wr && !in_data && !is_idx;
  end
endmodule

// File: rtl/ibr_wstage.sv
module ibr_wstage
  import ibr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  idx_wr,
  input  logic  dat_wr,
  input  lsel_t lane,
  input  lane_t wdata,
  input  logic  is_id,
  output logic  commit_fire,
  output logic  commit_q,
  output word_t word_q
);
  localparam lsel_t LAST = lsel_t'(LANES - 1);

  word_t stage;
  lsel_t prog;
  logic  in_order;

  assign in_order    = (lane == prog);
  assign commit_fire = dat_wr && (lane == LAST) && in_order;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage    <= '0;
      prog     <= '0;
      commit_q <= 1'b0;
      word_q   <= '0;
    end else begin
      commit_q <= commit_fire && !is_id;
      if (commit_fire && !is_id) word_q <= lane_put(stage, LAST, wdata);
      if (idx_wr) begin
        prog <= '0;
      end else if (dat_wr) begin
        if (lane == '0) begin
          stage <= lane_put(stage, lane, wdata);
          prog  <= lsel_t'(1);
        end else if (in_order && lane != LAST) begin
          stage <= lane_put(stage, lane, wdata);
          prog  <= prog + lsel_t'(1);
        end else begin
          prog <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ibr_rsnap.sv
module ibr_rsnap
  import ibr_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_rd,
  input  logic             dat_rd,
  input  logic             other_rd,
  input  lsel_t            lane,
  input  word_t            src_word,
  input  logic [IDX_W-1:0] idx_val,
  output lane_t            rdata_q
);
  word_t snap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap    <= '0;
      rdata_q <= '0;
    end else if (dat_rd) begin
      if (lane == '0) begin
        snap    <= src_word;
        rdata_q <= lane_get(src_word, lane);
      end else begin
        rdata_q <= lane_get(snap, lane);
      end
    end else if (idx_rd) begin
      rdata_q <= lane_t'(idx_val);
    end else if (other_rd) begin
      rdata_q <= '0;
    end
  end
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
  import ibr_pkg::*;
#(
  parameter int          ADDR_W     = 3,
  parameter int          IDX_W      = 8,
  parameter int          DATA_BASE  = 4,
  parameter int          ID_INDEX   = 0,
  parameter logic [7:0]  IMPL_CODE  = 8'h2A,
  parameter logic [7:0]  VER_CODE   = 8'h03,
  parameter logic [7:0]  PORT_COUNT = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_sel,
  input  logic              hst_wr,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [7:0]        hst_wdata,
  output logic [7:0]        hst_rdata,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              reg_wr,
  output logic [31:0]       reg_wdata,
  output logic              reg_rd,
  input  logic [31:0]       reg_rdata
);
  localparam word_t ID_VALUE = id_word(IMPL_CODE, VER_CODE, PORT_COUNT);

  logic  idx_wr, idx_rd, dat_wr, dat_rd, other_rd;
  lsel_t lane;
  logic  is_id;
  logic  commit_fire;
  word_t src_word;
  logic [IDX_W-1:0] idx_q;

  ibr_decode #(
    .ADDR_W(ADDR_W), .IDX_ADDR(0), .DATA_BASE(DATA_BASE)
  ) u_dec (
    .sel(hst_sel), .wr(hst_wr), .addr(hst_addr),
    .idx_wr(idx_wr), .idx_rd(idx_rd), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .other_rd(other_rd), .lane(lane)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_wr) idx_q <= IDX_W'(hst_wdata);
  end

  assign is_id    = (idx_q == IDX_W'(ID_INDEX));
  assign src_word = is_id ? ID_VALUE : reg_rdata;

  ibr_wstage u_wst (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .lane(lane), .wdata(hst_wdata), .is_id(is_id),
    .commit_fire(commit_fire), .commit_q(reg_wr), .word_q(reg_wdata)
  );

  ibr_rsnap #(.IDX_W(IDX_W)) u_rsn (
    .clk(clk), .rst_n(rst_n), .idx_rd(idx_rd), .dat_rd(dat_rd),
    .other_rd(other_rd), .lane(lane), .src_word(src_word),
    .idx_val(idx_q), .rdata_q(hst_rdata)
  );

  assign reg_idx = idx_q;
  assign reg_rd  = dat_rd && (lane == '0) && !is_id;
endmodule

// File: rtl/ibr_chk.sv
module ibr_chk #(
  parameter int ADDR_W    = 3,
  parameter int IDX_W     = 8,
  parameter int DATA_BASE = 4,
  parameter int ID_INDEX  = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hst_sel,
  input logic              hst_wr,
  input logic [ADDR_W-1:0] hst_addr,
  input logic [IDX_W-1:0]  reg_idx,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic              commit_fire
);
  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_wr_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(commit_fire && hst_sel && hst_wr &&
                     hst_addr == ADDR_W'(DATA_BASE + 3)));

  assert_no_wr_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_sel && hst_wr && hst_addr != ADDR_W'(DATA_BASE + 3)) |=> !reg_wr);

  assert_id_no_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> reg_idx != IDX_W'(ID_INDEX));

  assert_rd_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> (hst_sel && !hst_wr && hst_addr == ADDR_W'(DATA_BASE) &&
                reg_idx != IDX_W'(ID_INDEX)));

  assert_idx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hst_sel && hst_wr && hst_addr == '0) |=> $stable(reg_idx));
endmodule

bind ibr_bridge ibr_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_BASE(DATA_BASE), .ID_INDEX(ID_INDEX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
  .hst_addr(hst_addr), .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .commit_fire(commit_fire)
);

// File: tb/ibr_bridge_test.sv
module ibr_bridge_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_sel = 1'b0, hst_wr = 1'b0;
  logic [2:0]  hst_addr = '0;
  logic [7:0]  hst_wdata = '0;
  logic [7:0]  hst_rdata;
  logic [7:0]  reg_idx;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata = '0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ibr_bridge uut (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write access; returns the commit pulse seen in the following cycle
  task automatic hwrite(input logic [2:0] a, input logic [7:0] d, output logic cw);
    @(negedge clk);
    hst_sel = 1; hst_wr = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_sel = 0; hst_wr = 0;
    cw = reg_wr;
  endtask

  task automatic hread(input logic [2:0] a, output logic [7:0] d, output logic rs);
    @(negedge clk);
    hst_sel = 1; hst_wr = 0; hst_addr = a;
    #1 rs = reg_rd;
    @(negedge clk);
    hst_sel = 0;
    d = hst_rdata;
  endtask

  // big-endian byte k of w, restated independently
  function automatic logic [7:0] be_byte(logic [31:0] w, int k);
    return 8'(w >> (24 - 8 * k));
  endfunction

  task automatic t_reset;
    chk(reg_idx == 0, "R1 idx", 32'(reg_idx), 0);
    chk(hst_rdata == 0, "R1 rdata", 32'(hst_rdata), 0);
    chk(reg_wr == 0, "R1 wr", 32'(reg_wr), 0);
  endtask

  task automatic t_index;
    logic cw, rs; logic [7:0] d;
    hwrite(3'd0, 8'h05, cw);
    chk(reg_idx == 8'h05, "R2 idx load", 32'(reg_idx), 32'h05);
    hread(3'd0, d, rs);
    chk(d == 8'h05, "R2 idx readback", 32'(d), 32'h05);
    hread(3'd2, d, rs);
    chk(d == 8'h00, "R9 unmapped read", 32'(d), 0);
  endtask

  task automatic t_write_word(input logic [7:0] idx, input logic [31:0] w);
    logic cw;
    hwrite(3'd0, idx, cw);
    for (int k = 0; k < 3; k++) begin
      hwrite(3'(4 + k), be_byte(w, k), cw);
      chk(cw == 0, "R5 no early commit", 32'(cw), 0);
    end
    hwrite(3'd7, be_byte(w, 3), cw);
    chk(cw == 1, "R4 commit pulse", 32'(cw), 1);
    chk(reg_wdata == w, "R3 lane assembly", reg_wdata, w);
    @(negedge clk);
    chk(reg_wr == 0, "R4 single pulse", 32'(reg_wr), 0);
  endtask

  task automatic t_read_word;
    logic rs; logic [7:0] d; logic [31:0] w;
    w = 32'h1122_3344;
    reg_rdata = w;
    hread(3'd4, d, rs);
    chk(rs == 1, "R11 rd strobe", 32'(rs), 1);
    chk(d == be_byte(w, 0), "R9 lane0", 32'(d), 32'(be_byte(w, 0)));
    reg_rdata = 32'hFFFF_FFFF;
    for (int k = 1; k < 4; k++) begin
      hread(3'(4 + k), d, rs);
      chk(d == be_byte(w, k), "R8 snapshot lane", 32'(d), 32'(be_byte(w, k)));
      chk(rs == 0, "R11 no strobe", 32'(rs), 0);
    end
    @(negedge clk);
    chk(hst_rdata == be_byte(w, 3), "R9 hold", 32'(hst_rdata), 32'(be_byte(w, 3)));
  endtask

  task automatic t_out_of_order;
    logic cw;
    hwrite(3'd0, 8'h07, cw);
    hwrite(3'd4, 8'hAA, cw);
    hwrite(3'd6, 8'hBB, cw);
    hwrite(3'd7, 8'hCC, cw);
    chk(cw == 0, "R6 skipped lane no commit", 32'(cw), 0);
    hwrite(3'd5, 8'h11, cw);
    hwrite(3'd6, 8'h22, cw);
    hwrite(3'd7, 8'h33, cw);
    chk(cw == 0, "R6 missing lane0 no commit", 32'(cw), 0);
    t_write_word(8'h07, 32'hDEAD_BEEF);
  endtask

  task automatic t_abandon;
    logic cw;
    hwrite(3'd0, 8'h09, cw);
    hwrite(3'd4, 8'h01, cw);
    hwrite(3'd5, 8'h02, cw);
    hwrite(3'd6, 8'h03, cw);
    hwrite(3'd0, 8'h09, cw);
    hwrite(3'd7, 8'h04, cw);
    chk(cw == 0, "R7 abandoned", 32'(cw), 0);
    t_write_word(8'h09, 32'h0102_0304);
  endtask

  task automatic t_id;
    logic cw, rs; logic [7:0] d; logic [31:0] idw;
    idw = {8'h2A, 8'h03, 8'h02, 8'h00};
    reg_rdata = 32'h5555_5555;
    hwrite(3'd0, 8'h00, cw);
    for (int k = 0; k < 4; k++) begin
      hread(3'(4 + k), d, rs);
      chk(d == be_byte(idw, k), "R10 id lane", 32'(d), 32'(be_byte(idw, k)));
      chk(rs == 0, "R10 no rd strobe", 32'(rs), 0);
    end
    for (int k = 0; k < 4; k++) begin
      hwrite(3'(4 + k), 8'hEE, cw);
      chk(cw == 0, "R10 id write ignored", 32'(cw), 0);
    end
    hread(3'd4, d, rs);
    chk(d == 8'h2A, "R10 id unchanged", 32'(d), 32'h2A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_index;
    t_write_word(8'h05, 32'hA1B2_C3D4);
    t_write_word(8'h06, 32'h00FF_7F80);
    t_read_word;
    t_out_of_order;
    t_abandon;
    t_id;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule